// File: doc/BRIEF.md
# Keypad Wake-Up Edge and Level Detector

This block watches a group of already-synchronised keypad or wake-up pins and raises one shared, sticky event flag when an enabled pin becomes active. Every pin has an enable bit and a polarity bit. The polarity bit chooses whether the pin is active low, which gives falling-edge detection, or active high, which gives rising-edge detection. A mode bit chooses between two ways of detecting. In edge-only mode, only a transition from the inactive level to the active level counts. In edge-plus-level mode, a pin that is held at its active level also counts.

Edge detection is gated for the whole group. The detector is armed only after every enabled pin has been seen at its inactive level. Any accepted edge disarms it until all enabled pins are inactive again. Rewriting the enable mask or the polarity mask also disarms it, so a configuration change cannot create a false edge.

Software controls the block through a small register write port and a combinational read port. An interrupt-enable bit gates the flag onto the interrupt request output. Software clears the flag by writing 1 to a write-only acknowledge bit. In level mode that acknowledge is refused while any enabled pin is still active.

Top module: `kbw_top`

## Requirements
- R1: After reset, every readable register reads 0, the flag is 0 and `irq_o` is 0.
- R2: A pin with polarity bit 0 is active low and counts on a 1-to-0 change. A pin with polarity bit 1 is active high and counts on a 0-to-1 change. The flag reads 1 in the cycle after the clock edge at which the active level is first sampled.
- R3: A pin whose enable bit is 0 never raises the flag. Its level is also ignored when deciding whether all pins are inactive.
- R4: After an accepted edge, no further edge on any enabled pin is accepted until all enabled pins have been sampled inactive again.
- R5: A pin that is already active when it is enabled raises no flag in edge mode. It counts only after it has gone inactive and then active again.
- R6: With the level-mode bit (control bit 1) set, an enabled pin held active sets the flag. An acknowledge written while any enabled pin is active leaves the flag at 1.
- R7: Writing control bit 2 (acknowledge) as 1 clears the flag one cycle later when the clear is allowed. Writing it as 0 leaves the flag unchanged. The bit always reads 0.
- R8: `irq_o` is 1 exactly when the flag is 1 and control bit 0 (interrupt enable) is 1.
- R9: When a valid event and an acknowledge occur in the same cycle, the flag ends at 1.
- R10: A write to the enable mask or the polarity mask disarms edge detection until all enabled pins are sampled inactive under the new settings.
- R11: The register map is:
  - Address 0 is control: bit 0 interrupt enable (read/write), bit 1 level mode (read/write), bit 2 acknowledge (write-only, reads 0), bit 3 flag (read-only).
  - Address 1 is the pin enable mask.
  - Address 2 is the polarity mask.
  - Address 3 reads 0.
  - Masks read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | N_PINS | Synchronised pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench holds one enabled pin active and then drives an edge on a second pin. A detector without group gating would set the flag on that second edge. It enables a pin that is already active and also flips polarity under a quiet pin. A detector that is not disarmed by configuration writes would report a false edge in both cases. In level mode, it acknowledges while the pin is still held active. A design that lets the clear through would show the flag at 0. It also drives an edge and an acknowledge in the same cycle, where a clear-first design would lose the event.

// File: rtl/kbw_pkg.sv
package kbw_pkg;
   localparam int ADDR_W   = 2;
   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_EN   = 2'd1;
   localparam logic [ADDR_W-1:0] A_POL  = 2'd2;
   localparam int B_IRQEN  = 0;
   localparam int B_LEVEL  = 1;
   localparam int B_ACK    = 2;
   localparam int B_FLAG   = 3;
   localparam int CTRL_BITS = 4;
endpackage

// File: rtl/kbw_regs.sv
module kbw_regs
   import kbw_pkg::*;
#(
   parameter int N_PINS   = 8,
   parameter int DATA_W   = 8,
   parameter bit LEVEL_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              flag_i,
   output logic [N_PINS-1:0] pin_en_o,
   output logic [N_PINS-1:0] pin_pol_o,
   output logic              irq_en_o,
   output logic              level_mode_o,
   output logic              ack_o,
   output logic              cfg_chg_o
);
   logic wr_ctrl, wr_mask_en, wr_mask_pol;

   assign wr_ctrl     = wr_en_i && (wr_addr_i == A_CTRL);
   assign wr_mask_en  = wr_en_i && (wr_addr_i == A_EN);
   assign wr_mask_pol = wr_en_i && (wr_addr_i == A_POL);
   assign ack_o       = wr_ctrl && wr_data_i[B_ACK];
   assign cfg_chg_o   = wr_mask_en || wr_mask_pol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_en_o  <= '0;
         pin_pol_o <= '0;
         irq_en_o  <= 1'b0;
      end else begin
         if (wr_mask_en)  pin_en_o  <= wr_data_i[N_PINS-1:0];
         if (wr_mask_pol) pin_pol_o <= wr_data_i[N_PINS-1:0];
         if (wr_ctrl)     irq_en_o  <= wr_data_i[B_IRQEN];
      end
   end

   generate
      if (LEVEL_OK) begin : g_level
         logic level_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       level_q <= 1'b0;
            else if (wr_ctrl) level_q <= wr_data_i[B_LEVEL];
         end
         assign level_mode_o = level_q;
      end else begin : g_edge_only
         assign level_mode_o = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         A_CTRL: begin
            rd_data_o[B_IRQEN] = irq_en_o;
            rd_data_o[B_LEVEL] = level_mode_o;
            rd_data_o[B_FLAG]  = flag_i;
         end
         A_EN:    rd_data_o[N_PINS-1:0] = pin_en_o;
         A_POL:   rd_data_o[N_PINS-1:0] = pin_pol_o;
         default: rd_data_o = '0;
      endcase
   end

   a_r7_ack_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> wr_en_i);
endmodule

// File: rtl/kbw_detect.sv
module kbw_detect #(
   parameter int N_PINS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pins_i,
   input  logic [N_PINS-1:0] pin_en_i,
   input  logic [N_PINS-1:0] pin_pol_i,
   input  logic              level_mode_i,
   input  logic              cfg_chg_i,
   output logic              event_o,
   output logic              any_active_o
);
   logic [N_PINS-1:0] active, active_q, rise;
   logic              armed_q, edge_any;

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      assign active[i] = pin_pol_i[i] ? pins_i[i] : ~pins_i[i];
      assign rise[i]   = pin_en_i[i] & active[i] & ~active_q[i];
   end

   assign any_active_o = |(active & pin_en_i);
   assign edge_any     = armed_q & (|rise);
   assign event_o      = edge_any | (level_mode_i & any_active_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= '0;
         armed_q  <= 1'b0;
      end else begin
         active_q <= active;
         if (cfg_chg_i || edge_any) armed_q <= 1'b0;
         else if (!any_active_o)    armed_q <= 1'b1;
      end
   end

   a_r4_edge_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      edge_any |=> !armed_q);
   a_r10_cfg_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg_i |=> !armed_q);
   a_r4_arm_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_chg_i && !any_active_o) |=> armed_q);
endmodule

// File: rtl/kbw_flag.sv
module kbw_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic event_i,
   input  logic ack_i,
   input  logic level_mode_i,
   input  logic any_active_i,
   output logic flag_o
);
   logic ack_ok;

   assign ack_ok = ack_i & ~(level_mode_i & any_active_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_o <= 1'b0;
      else if (event_i) flag_o <= 1'b1;
      else if (ack_ok)  flag_o <= 1'b0;
   end

   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      event_i |=> flag_o);
   a_r6_ack_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && level_mode_i && any_active_i) |=> flag_o);
   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !event_i && !(level_mode_i && any_active_i)) |=> !flag_o);
   a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_i && !event_i) |=> $stable(flag_o));
endmodule

// File: rtl/kbw_top.sv
module kbw_top
   import kbw_pkg::*;
#(
   parameter int N_PINS   = 8,
   parameter int DATA_W   = 8,
   parameter bit LEVEL_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pins_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [1:0]        rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);
   generate
      if (N_PINS < 1)         begin : g_bad_pins  $error("N_PINS must be at least 1"); end
      if (DATA_W < N_PINS)    begin : g_bad_width $error("DATA_W must hold N_PINS"); end
      if (DATA_W < CTRL_BITS) begin : g_bad_ctrl  $error("DATA_W too narrow for control"); end
   endgenerate

   logic [N_PINS-1:0] pin_en, pin_pol;
   logic irq_en, level_mode, ack, cfg_chg, evt, any_active, flag;

   kbw_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W), .LEVEL_OK(LEVEL_OK)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
      .flag_i(flag), .pin_en_o(pin_en), .pin_pol_o(pin_pol), .irq_en_o(irq_en),
      .level_mode_o(level_mode), .ack_o(ack), .cfg_chg_o(cfg_chg));

   kbw_detect #(.N_PINS(N_PINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .pin_en_i(pin_en),
      .pin_pol_i(pin_pol), .level_mode_i(level_mode), .cfg_chg_i(cfg_chg),
      .event_o(evt), .any_active_o(any_active));

   kbw_flag u_flag (
      .clk(clk), .rst_n(rst_n), .event_i(evt), .ack_i(ack),
      .level_mode_i(level_mode), .any_active_i(any_active), .flag_o(flag));

   assign irq_o = flag & irq_en;

   a_r8_irq_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && $rose(flag)) |-> irq_o);
endmodule

// File: tb/test_kbw_top.sv
module test_kbw_top;
   localparam int NP = 8;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pins = '1;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0]    rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          irq;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   kbw_top #(.N_PINS(NP), .DATA_W(DW)) i_kbw_top (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic get_flag(output logic f);
      logic [DW-1:0] d;
      rd(2'd0, d);
      f = d[3];
   endtask

   task automatic setup(input logic [NP-1:0] en, input logic [NP-1:0] pol,
                        input logic [DW-1:0] ctrl, input logic [NP-1:0] lv);
      wr(2'd1, '0);
      pins = lv;
      wr(2'd0, 8'h04);
      wr(2'd2, pol);
      wr(2'd1, en);
      wr(2'd0, ctrl);
      idle(2);
   endtask

   task automatic t_reset;
      logic [DW-1:0] d;
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], d);
         check("R1 reset read", d, 0);
      end
      check("R1 reset irq", irq, 0);
   endtask

   task automatic t_regs;
      logic [DW-1:0] d;
      wr(2'd1, 8'hA5); rd(2'd1, d); check("R11 enable readback", d, 8'hA5);
      wr(2'd2, 8'h5A); rd(2'd2, d); check("R11 polarity readback", d, 8'h5A);
      wr(2'd0, 8'h05); rd(2'd0, d); check("R11 ctrl readback, R7 ack reads 0", d & 8'h07, 8'h01);
      rd(2'd3, d); check("R11 unused address", d, 0);
      wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h04);
   endtask

   task automatic t_falling;
      logic f;
      setup(8'h01, 8'h00, 8'h01, 8'hFF);
      get_flag(f); check("R2 flag quiet before edge", f, 0);
      @(negedge clk); pins[0] = 1'b0;
      @(negedge clk); get_flag(f);
      check("R2 falling edge sets flag", f, 1);
      check("R8 irq with enable", irq, 1);
      wr(2'd0, 8'h00);
      get_flag(f); check("R7 ack bit 0 keeps flag", f, 1);
      check("R8 irq masked", irq, 0);
      wr(2'd0, 8'h05);
      get_flag(f); check("R7 ack clears flag", f, 0);
      idle(3); get_flag(f); check("R4 held pin gives no new edge", f, 0);
   endtask

   task automatic t_rising;
      logic f;
      setup(8'h04, 8'h04, 8'h00, 8'hFB);
      @(negedge clk); pins[2] = 1'b1;
      @(negedge clk); get_flag(f); check("R2 rising edge sets flag", f, 1);
      wr(2'd0, 8'h04);
   endtask

   task automatic t_rearm;
      logic f;
      setup(8'h03, 8'h00, 8'h00, 8'hFF);
      @(negedge clk); pins[0] = 1'b0;
      @(negedge clk); wr(2'd0, 8'h04);
      @(negedge clk); pins[1] = 1'b0;
      idle(2); get_flag(f); check("R4 second edge blocked while pin0 active", f, 0);
      pins = 8'hFF; idle(2);
      pins[1] = 1'b0;
      @(negedge clk); get_flag(f); check("R4 edge accepted after all inactive", f, 1);
      wr(2'd0, 8'h04);
   endtask

   task automatic t_disabled;
      logic f;
      setup(8'h01, 8'h00, 8'h00, 8'hFF);
      @(negedge clk); pins[5] = 1'b0;
      idle(2); get_flag(f); check("R3 disabled pin ignored", f, 0);
      pins[0] = 1'b0;
      @(negedge clk); get_flag(f); check("R3 disabled active pin does not block arming", f, 1);
      wr(2'd0, 8'h04);
   endtask

   task automatic t_cfg;
      logic f;
      setup(8'h01, 8'h00, 8'h00, 8'hFE);
      idle(2); get_flag(f); check("R5 enabled while active gives no edge", f, 0);
      pins[0] = 1'b1; idle(2);
      pins[0] = 1'b0;
      @(negedge clk); get_flag(f); check("R5 edge after going inactive", f, 1);
      wr(2'd0, 8'h04);
      setup(8'h01, 8'h00, 8'h00, 8'hFF);
      wr(2'd2, 8'h01);
      idle(2); get_flag(f); check("R10 polarity flip gives no false edge", f, 0);
      pins[0] = 1'b0; idle(2);
      pins[0] = 1'b1;
      @(negedge clk); get_flag(f); check("R10 edge after rearm under new polarity", f, 1);
      wr(2'd0, 8'h04);
   endtask

   task automatic t_level;
      logic f;
      setup(8'h01, 8'h00, 8'h02, 8'hFE);
      get_flag(f); check("R6 held level sets flag", f, 1);
      wr(2'd0, 8'h06);
      get_flag(f); check("R6 ack refused while active", f, 1);
      pins[0] = 1'b1; @(negedge clk);
      wr(2'd0, 8'h06);
      get_flag(f); check("R6 ack accepted once inactive", f, 0);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_setwins;
      logic f;
      setup(8'h01, 8'h00, 8'h00, 8'hFF);
      @(negedge clk);
      pins[0] = 1'b0; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h04;
      @(negedge clk); wr_en = 1'b0;
      get_flag(f); check("R9 event beats ack", f, 1);
      wr(2'd0, 8'h04);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #1;
      t_reset;
      idle(2);
      rst_n = 1'b1;
      idle(2);
      t_reset;
      t_regs;
      t_falling;
      t_rising;
      t_rearm;
      t_disabled;
      t_cfg;
      t_level;
      t_setwins;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule